// File: doc/BRIEF.md
# Power-Good Strap Latch Controller

This block takes the board's clock-frequency strap pins and latches them exactly once, when the power-good input is first seen high. Every input first passes through a two-flop synchronizer. The latched strap word is held on registered outputs. A raw 3-bit CPU select code, a decoded 2-bit CPU frequency code and a 1-bit SATA select come out, together with a flag that marks the codes as valid. Once the codes are latched, later strap and power-good activity is ignored. A test-mode input removes that lock so the straps can be swept.

A second, independent path drives the enable for the 25 MHz suspend-domain reference. The enable follows suspend power, so wake-on-LAN works from the first power-up without any configuration. A wake-on-LAN enable bit from the register file can turn this off. When that bit is cleared, the wake-on-LAN stop pin acts as an active-low power-down request.

The block carries no data stream, so it has no valid/ready interface. Every pin is a plain level, and no pin applies back-pressure.

Top module: `strap_latch_ctrl`

## Requirements
- R1: After reset, and for as long as no capture has happened, `sel_valid`, `cpu_sel`, `cpu_freq` and `sata_sel` are all 0.
- R2: The first time synchronized power-good is high, the straps are captured: `cpu_sel` = `fs_strap`, `sata_sel` = `sata_strap`, and `sel_valid` = 1. These values are visible on the third rising clock edge after the inputs change.
- R3: Outside test mode, once `sel_valid` is 1, the outputs do not change when `fs_strap` or `sata_strap` change, when `pwr_good` falls, or when `pwr_good` rises again.
- R4: In test mode, while power-good is high, the outputs follow the straps with the same latency as R2. Power-good low in test mode clears `sel_valid` and the codes to 0. This re-arms the one-shot capture for when test mode is left.
- R5: `cpu_freq` decodes `cpu_sel[2:1]`: 0 = 100 MHz, 1 = 83.33 MHz, 2 = 133.33 MHz, 3 = 166.67 MHz. `cpu_sel[0]` does not affect it.
- R6: `sata_sel` = 0 selects 100 MHz SATA and `sata_sel` = 1 selects 75 MHz SATA. SRC (100 MHz) and PCI (33.33 MHz) are fixed and need no code.
- R7: `ref25_en` = `susp_pwr` AND (`wol_en` OR `wol_stop_n`), whatever the state of power-good or the latch. With `wol_en` = 1, `wol_stop_n` has no effect.
- R8: `pd_req` = 1 exactly when `wol_en` = 0 and `wol_stop_n` = 0. `pd_req` and `ref25_en` are never both 1.
- R9: On a first power-up with only `susp_pwr` high, `pwr_good` low and `wol_en` at its default of 1, `ref25_en` is 1 within four clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fs_strap | input | 3 | Frequency-select strap pins |
| sata_strap | input | 1 | SATA frequency strap |
| pwr_good | input | 1 | Power-good, asynchronous |
| test_mode | input | 1 | Disables the one-shot lock |
| susp_pwr | input | 1 | Suspend power present |
| wol_stop_n | input | 1 | Wake-on-LAN stop pin, used as active-low power-down when `wol_en` = 0 |
| wol_en | input | 1 | Wake-on-LAN enable bit from the register file (default 1) |
| cpu_sel | output | 3 | Latched raw FS code |
| cpu_freq | output | 2 | Decoded CPU frequency code |
| sata_sel | output | 1 | Latched SATA select |
| sel_valid | output | 1 | Codes have been captured |
| ref25_en | output | 1 | 25 MHz reference enable |
| pd_req | output | 1 | Power-down request |

## Verification
The bench walks all sixteen strap combinations through a fresh power-good capture. It then disturbs the straps and power-good. A design that re-sampled on every power-good edge, or that tracked the straps after locking, would show the disturbed code. The same sweep is repeated in test mode. There, a design that kept the lock would freeze on the first code, and one that ignored a power-good drop would keep `sel_valid` high. All eight combinations of suspend power, enable bit and stop pin are applied. This catches a stop pin that gates the reference while wake-on-LAN is enabled, and a power-down request raised while the enable bit is set.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int FS_BITS   = 3;
  localparam int FREQ_BITS = 2;

  typedef enum logic [FREQ_BITS-1:0] {
    CPU_F100 = 2'd0,
    CPU_F083 = 2'd1,
    CPU_F133 = 2'd2,
    CPU_F167 = 2'd3
  } cpu_freq_e;

  typedef struct packed {
    logic               sata;
    logic [FS_BITS-1:0] fs;
  } strap_t;

  localparam int STRAP_BITS = $bits(strap_t);

  function automatic cpu_freq_e decode_cpu(input logic [FS_BITS-1:0] fs);
    return cpu_freq_e'(fs[FS_BITS-1 -: FREQ_BITS]);
  endfunction
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= RST_VAL;
          else        stg[i] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= RST_VAL;
          else        stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/strap_capture.sv
module strap_capture
  import strap_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pg_s,
  input  logic      tm_s,
  input  strap_t    straps_s,
  output strap_t    held,
  output cpu_freq_e freq,
  output logic      valid
);
  // One-shot latch; test mode tracks power-good and straps freely.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held  <= '0;
      freq  <= CPU_F100;
      valid <= 1'b0;
    end else if (tm_s) begin
      if (pg_s) begin
        held  <= straps_s;
        freq  <= decode_cpu(straps_s.fs);
        valid <= 1'b1;
      end else begin
        held  <= '0;
        freq  <= CPU_F100;
        valid <= 1'b0;
      end
    end else if (!valid && pg_s) begin
      held  <= straps_s;
      freq  <= decode_cpu(straps_s.fs);
      valid <= 1'b1;
    end
  end
endmodule

// File: rtl/ref_enable_ctrl.sv
module ref_enable_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic susp_s,
  input  logic stop_n_s,
  input  logic wol_en,
  output logic ref_en,
  output logic pd_req
);
  logic pd_now;
  assign pd_now = !wol_en && !stop_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_en <= 1'b0;
      pd_req <= 1'b0;
    end else begin
      ref_en <= susp_s && !pd_now;
      pd_req <= pd_now;
    end
  end
endmodule

// File: rtl/strap_latch_ctrl.sv
module strap_latch_ctrl
  import strap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [FS_BITS-1:0]   fs_strap,
  input  logic                 sata_strap,
  input  logic                 pwr_good,
  input  logic                 test_mode,
  input  logic                 susp_pwr,
  input  logic                 wol_stop_n,
  input  logic                 wol_en,
  output logic [FS_BITS-1:0]   cpu_sel,
  output logic [FREQ_BITS-1:0] cpu_freq,
  output logic                 sata_sel,
  output logic                 sel_valid,
  output logic                 ref25_en,
  output logic                 pd_req
);
  localparam int BUS_W = STRAP_BITS + 4;
  localparam logic [BUS_W-1:0] BUS_RST = {1'b1, {(BUS_W-1){1'b0}}};

  logic [BUS_W-1:0] bus_raw, bus_s;
  strap_t    straps_s, held;
  cpu_freq_e freq;
  logic pg_s, tm_s, susp_s, stop_n_s;

  assign bus_raw = {wol_stop_n, susp_pwr, test_mode, pwr_good, sata_strap, fs_strap};

  strap_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_raw), .q(bus_s)
  );

  assign {stop_n_s, susp_s, tm_s, pg_s} = bus_s[BUS_W-1 -: 4];
  assign straps_s = strap_t'(bus_s[STRAP_BITS-1:0]);

  strap_capture u_cap (
    .clk(clk), .rst_n(rst_n), .pg_s(pg_s), .tm_s(tm_s),
    .straps_s(straps_s), .held(held), .freq(freq), .valid(sel_valid)
  );

  ref_enable_ctrl u_ref (
    .clk(clk), .rst_n(rst_n), .susp_s(susp_s), .stop_n_s(stop_n_s),
    .wol_en(wol_en), .ref_en(ref25_en), .pd_req(pd_req)
  );

  assign cpu_sel  = held.fs;
  assign sata_sel = held.sata;
  assign cpu_freq = freq;
endmodule

// File: rtl/strap_latch_ctrl_chk.sv
module strap_latch_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] cpu_sel,
  input logic [1:0] cpu_freq,
  input logic       sata_sel,
  input logic       sel_valid,
  input logic       ref25_en,
  input logic       pd_req,
  input logic       pg_s,
  input logic       tm_s,
  input logic       wol_en
);
  a_r1_zero_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |-> (cpu_sel == 3'd0 && cpu_freq == 2'd0 && !sata_sel));

  a_r1_no_early_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_valid && !pg_s) |=> !sel_valid);

  a_r2_capture_on_pg: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_valid && pg_s) |=> sel_valid);

  a_r3_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && !tm_s) |=> (sel_valid && $stable(cpu_sel) && $stable(sata_sel)));

  a_r4_test_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (tm_s && !pg_s) |=> !sel_valid);

  a_r5_decode: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (cpu_freq == cpu_sel[2:1]));

  a_r8_pd_excl: assert property (@(posedge clk) disable iff (!rst_n)
    pd_req |-> !ref25_en);

  a_r8_pd_needs_wol_off: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_req) |-> !$past(wol_en));
endmodule

bind strap_latch_ctrl strap_latch_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_freq(cpu_freq),
  .sata_sel(sata_sel), .sel_valid(sel_valid), .ref25_en(ref25_en),
  .pd_req(pd_req), .pg_s(pg_s), .tm_s(tm_s), .wol_en(wol_en)
);

// File: tb/strap_latch_ctrl_tb.sv
module strap_latch_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] fs_strap = '0;
  logic       sata_strap = 1'b0, pwr_good = 1'b0, test_mode = 1'b0;
  logic       susp_pwr = 1'b0, wol_stop_n = 1'b1, wol_en = 1'b1;
  logic [2:0] cpu_sel;
  logic [1:0] cpu_freq;
  logic       sata_sel, sel_valid, ref25_en, pd_req;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  strap_latch_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .fs_strap(fs_strap), .sata_strap(sata_strap),
    .pwr_good(pwr_good), .test_mode(test_mode), .susp_pwr(susp_pwr),
    .wol_stop_n(wol_stop_n), .wol_en(wol_en), .cpu_sel(cpu_sel),
    .cpu_freq(cpu_freq), .sata_sel(sata_sel), .sel_valid(sel_valid),
    .ref25_en(ref25_en), .pd_req(pd_req)
  );

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic check_codes(input int code, input int valid, input string tag);
    check(sel_valid, valid, {tag, " valid"});
    check(cpu_sel, valid ? (code & 7) : 0, {tag, " cpu_sel"});
    check(cpu_freq, valid ? ((code >> 1) & 3) : 0, {tag, " cpu_freq R5"});
    check(sata_sel, valid ? ((code >> 3) & 1) : 0, {tag, " sata_sel R6"});
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R9: first power-up, suspend power only
    susp_pwr = 1'b1;
    do_reset();
    check_codes(0, 0, "R1 reset");
    settle();
    check(ref25_en, 1, "R9 ref on first power-up");
    check(sel_valid, 0, "R1 no capture with pg low");

    // R2/R3: one-shot capture across all strap combinations
    for (int v = 0; v < 16; v++) begin
      do_reset();
      fs_strap = v[2:0]; sata_strap = v[3];
      settle();
      check_codes(0, 0, "R1 straps without pg");
      pwr_good = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check(sel_valid, 0, "R2 not before third edge");
      @(posedge clk);
      @(negedge clk);
      check_codes(v, 1, "R2 capture");
      fs_strap = ~v[2:0]; sata_strap = ~v[3];
      settle();
      check_codes(v, 1, "R3 strap change ignored");
      pwr_good = 1'b0;
      settle();
      check_codes(v, 1, "R3 pg drop ignored");
      pwr_good = 1'b1;
      settle();
      check_codes(v, 1, "R3 pg re-rise ignored");
      pwr_good = 1'b0;
    end

    // R4: test mode follows straps and power-good
    do_reset();
    test_mode = 1'b1; pwr_good = 1'b1;
    for (int v = 0; v < 16; v++) begin
      fs_strap = v[2:0]; sata_strap = v[3];
      settle();
      check_codes(v, 1, "R4 test mode follow");
    end
    pwr_good = 1'b0;
    settle();
    check_codes(0, 0, "R4 test mode pg low clears");
    test_mode = 1'b0;
    fs_strap = 3'd5; sata_strap = 1'b1;
    settle();
    pwr_good = 1'b1;
    settle();
    check_codes(13, 1, "R4 re-armed capture");
    fs_strap = 3'd2; sata_strap = 1'b0;
    settle();
    check_codes(13, 1, "R3 locked after test mode");

    // R7/R8: reference enable and power-down, all combinations
    for (int c = 0; c < 8; c++) begin
      susp_pwr = c[0]; wol_en = c[1]; wol_stop_n = c[2];
      settle();
      check(ref25_en, (c[0] && (c[1] || c[2])) ? 1 : 0, "R7 ref enable");
      check(pd_req, (!c[1] && !c[2]) ? 1 : 0, "R8 power-down");
    end
    check_codes(13, 1, "R7 ref path leaves codes alone");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule